// File: doc/BRIEF.md
# Hands-Free Voice Switch Mode Controller

This block is the digital decision core of a speakerphone voice switch. Each clock it reads two level-comparison flags, a speech/noise flag for each direction and a dial-tone flag. From these it picks one of four modes: transmit, receive, idle or change. The chosen mode is registered and exposed on `mode_o`.

The mode steers a signed control ramp. Full transmit pulls the ramp to its negative clamp and full receive pulls it to its positive clamp. Change mode and idle both pull it back to zero. Idle uses a slow step rate; the other three modes use a fast one. Two attenuation codes are derived linearly from the ramp and drive the transmit and receive attenuators. A sensing-select input chooses between the full four-flag decision and a reduced decision that uses only the direct comparison and ignores the noise monitors.

Top module: `vsw_ctrl`

## Requirements
- R1: In 4-point sensing (`four_point_i`=1), when both comparison flags are 1 (favour transmit) and `tx_speech_i`=1, the next registered mode is transmit (`mode_o`=1).
- R2: In 4-point sensing, when both comparison flags are 0 (favour receive) and `rx_speech_i`=1, the next mode is receive (`mode_o`=2).
- R3: In 4-point sensing, when the two comparison flags differ and at least one speech flag is 1, the next mode is change (`mode_o`=3).
- R4: In 4-point sensing, the next mode is idle (`mode_o`=0) in three cases: both flags favour transmit with `tx_speech_i`=0; both flags favour receive with `rx_speech_i`=0 and `dial_tone_i`=0; or the flags differ with both speech flags 0.
- R5: In 4-point sensing, when both flags favour receive, `rx_speech_i`=0 and `dial_tone_i`=1, the mode is receive rather than idle.
- R6: In 2-point sensing (`four_point_i`=0), the next mode is transmit when `cmp_a_tx_i`=1 and receive otherwise. `cmp_b_tx_i`, both speech flags and `dial_tone_i` have no effect.
- R7: The ramp moves by one step at a time toward a target and never goes past it. The target is -2^(RAMP_W-1) in transmit, 2^(RAMP_W-1)-1 in receive, and 0 in idle and change.
- R8: A mode switch restarts step timing, and the ramp holds in the switch cycle. Then, in transmit, receive and change, the ramp steps every FAST_DIV cycles; in idle it steps every SLOW_DIV cycles.
- R9: With ramp value v, `tx_att_o` = (v + 2^(RAMP_W-1)) / 2 and `rx_att_o` = (2^(RAMP_W-1) - 1 - v) / 2, both rounded down. A code of 0 means no attenuation and an all-ones code means maximum attenuation.
- R10: During reset the mode is idle and the ramp is 0, so the codes are 64 (transmit) and 63 (receive) at the default width.
- R11: The mode output changes at the first clock edge after the inputs change, through one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_a_tx_i | input | 1 | Direct log comparison, 1 = transmit level higher |
| cmp_b_tx_i | input | 1 | Cross (calculated) comparison, 1 = transmit level higher |
| tx_speech_i | input | 1 | Transmit noise monitor, 1 = speech, 0 = noise |
| rx_speech_i | input | 1 | Receive noise monitor, 1 = speech, 0 = noise |
| dial_tone_i | input | 1 | Dial tone present on receive path |
| four_point_i | input | 1 | 1 = 4-point sensing, 0 = 2-point sensing |
| mode_o | output | 2 | 0 idle, 1 transmit, 2 receive, 3 change |
| ramp_o | output | RAMP_W | Signed control ramp |
| tx_att_o | output | RAMP_W-1 | Transmit attenuation code |
| rx_att_o | output | RAMP_W-1 | Receive attenuation code |

## Verification
All 32 combinations of the two comparisons, both speech flags and the dial-tone flag are applied in each sensing mode. Each result is compared with the truth table. The 4-point sweep distinguishes agreeing from disagreeing comparisons and speech from noise in each direction, and it isolates the case where the dial tone keeps receive active. The 2-point sweep shows that every input other than the direct comparison is ignored. Ramp sequences run transmit, receive, idle, change and dial-tone receive in turn and check the ramp and both codes every cycle. Together they separate the fast and slow rates, confirm that each clamp end is reached and held, and confirm that change mode returns the ramp to the centre from a partial excursion.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_TX   = 2'd1,
    M_RX   = 2'd2,
    M_CHG  = 2'd3
  } vsw_mode_e;
endpackage

// File: rtl/vsw_mode_decide.sv
module vsw_mode_decide
  import vsw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmp_a_tx_i,
  input  logic      cmp_b_tx_i,
  input  logic      tx_speech_i,
  input  logic      rx_speech_i,
  input  logic      dial_tone_i,
  input  logic      four_point_i,
  output vsw_mode_e mode_q_o,
  output logic      switch_o
);
  vsw_mode_e mode_d, mode_q;
  logic agree_tx, agree_rx, any_speech;

  assign agree_tx   = cmp_a_tx_i & cmp_b_tx_i;
  assign agree_rx   = ~cmp_a_tx_i & ~cmp_b_tx_i;
  assign any_speech = tx_speech_i | rx_speech_i;

  always_comb begin
    if (!four_point_i) begin
      mode_d = cmp_a_tx_i ? M_TX : M_RX;
    end else if (agree_tx) begin
      mode_d = tx_speech_i ? M_TX : M_IDLE;
    end else if (agree_rx) begin
      // dial tone keeps receive from decaying to idle
      mode_d = (rx_speech_i | dial_tone_i) ? M_RX : M_IDLE;
    end else begin
      mode_d = any_speech ? M_CHG : M_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= M_IDLE;
    else         mode_q <= mode_d;
  end

  assign mode_q_o = mode_q;
  assign switch_o = (mode_d != mode_q);
endmodule

// File: rtl/vsw_step_timer.sv
module vsw_step_timer #(
  parameter int unsigned FAST_DIV = 117,
  parameter int unsigned SLOW_DIV = 5859
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic slow_i,
  output logic step_o
);
  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt_q, last;

  assign last   = slow_i ? SLOW_LAST : FAST_LAST;
  assign step_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || step_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vsw_ramp.sv
module vsw_ramp
  import vsw_pkg::*;
#(
  parameter int unsigned RAMP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  vsw_mode_e                mode_i,
  input  logic                     hold_i,
  input  logic                     step_i,
  output logic signed [RAMP_W-1:0] ramp_o
);
  localparam logic signed [RAMP_W-1:0] NEG_END = {1'b1, {(RAMP_W-1){1'b0}}};
  localparam logic signed [RAMP_W-1:0] POS_END = {1'b0, {(RAMP_W-1){1'b1}}};
  localparam logic signed [RAMP_W-1:0] ONE     = RAMP_W'(1);

  logic signed [RAMP_W-1:0] ramp_q, target;

  always_comb begin
    unique case (mode_i)
      M_TX:    target = NEG_END;
      M_RX:    target = POS_END;
      default: target = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
    end else if (step_i && !hold_i) begin
      if (ramp_q > target)      ramp_q <= ramp_q - ONE;
      else if (ramp_q < target) ramp_q <= ramp_q + ONE;
    end
  end

  assign ramp_o = ramp_q;
endmodule

// File: rtl/vsw_att_map.sv
module vsw_att_map #(
  parameter int unsigned RAMP_W = 8,
  localparam int unsigned ATT_W = RAMP_W - 1
) (
  input  logic signed [RAMP_W-1:0] ramp_i,
  output logic [ATT_W-1:0]         tx_att_o,
  output logic [ATT_W-1:0]         rx_att_o
);
  logic [RAMP_W-1:0] offs;

  // offset binary: ramp + 2^(RAMP_W-1)
  assign offs     = {~ramp_i[RAMP_W-1], ramp_i[RAMP_W-2:0]};
  assign tx_att_o = offs[RAMP_W-1:1];
  // (max - ramp) is the complement of the offset value
  assign rx_att_o = ~offs[RAMP_W-1:1];
endmodule

// File: rtl/vsw_ctrl.sv
module vsw_ctrl
  import vsw_pkg::*;
#(
  parameter int unsigned RAMP_W   = 8,
  parameter int unsigned FAST_DIV = 117,
  parameter int unsigned SLOW_DIV = 5859,
  localparam int unsigned ATT_W   = RAMP_W - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmp_a_tx_i,
  input  logic                     cmp_b_tx_i,
  input  logic                     tx_speech_i,
  input  logic                     rx_speech_i,
  input  logic                     dial_tone_i,
  input  logic                     four_point_i,
  output logic [1:0]               mode_o,
  output logic signed [RAMP_W-1:0] ramp_o,
  output logic [ATT_W-1:0]         tx_att_o,
  output logic [ATT_W-1:0]         rx_att_o
);
  vsw_mode_e mode_q;
  logic      mode_switch, step;

  vsw_mode_decide u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmp_a_tx_i  (cmp_a_tx_i),
    .cmp_b_tx_i  (cmp_b_tx_i),
    .tx_speech_i (tx_speech_i),
    .rx_speech_i (rx_speech_i),
    .dial_tone_i (dial_tone_i),
    .four_point_i(four_point_i),
    .mode_q_o    (mode_q),
    .switch_o    (mode_switch)
  );

  vsw_step_timer #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(mode_switch),
    .slow_i   (mode_q == M_IDLE),
    .step_o   (step)
  );

  vsw_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_q),
    .hold_i(mode_switch),
    .step_i(step),
    .ramp_o(ramp_o)
  );

  vsw_att_map #(.RAMP_W(RAMP_W)) u_map (
    .ramp_i  (ramp_o),
    .tx_att_o(tx_att_o),
    .rx_att_o(rx_att_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/vsw_ctrl_chk.sv
module vsw_ctrl_chk #(
  parameter int unsigned RAMP_W = 8,
  localparam int unsigned ATT_W = RAMP_W - 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cmp_a_tx_i,
  input logic                     cmp_b_tx_i,
  input logic                     tx_speech_i,
  input logic                     rx_speech_i,
  input logic                     dial_tone_i,
  input logic                     four_point_i,
  input logic [1:0]               mode_o,
  input logic signed [RAMP_W-1:0] ramp_o,
  input logic [ATT_W-1:0]         tx_att_o,
  input logic [ATT_W-1:0]         rx_att_o
);
  localparam logic signed [RAMP_W-1:0] NEG_END = {1'b1, {(RAMP_W-1){1'b0}}};
  localparam logic signed [RAMP_W-1:0] ONE     = RAMP_W'(1);

  a_r1_tx_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_point_i && cmp_a_tx_i && cmp_b_tx_i && tx_speech_i) |=> (mode_o == 2'd1));

  a_r2_rx_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_point_i && !cmp_a_tx_i && !cmp_b_tx_i && rx_speech_i) |=> (mode_o == 2'd2));

  a_r3_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_point_i && (cmp_a_tx_i != cmp_b_tx_i) && (tx_speech_i || rx_speech_i))
    |=> (mode_o == 2'd3));

  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_point_i && ((cmp_a_tx_i && cmp_b_tx_i && !tx_speech_i) ||
                      (!cmp_a_tx_i && !cmp_b_tx_i && !rx_speech_i && !dial_tone_i) ||
                      ((cmp_a_tx_i != cmp_b_tx_i) && !tx_speech_i && !rx_speech_i)))
    |=> (mode_o == 2'd0));

  a_r5_dial_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_point_i && !cmp_a_tx_i && !cmp_b_tx_i && dial_tone_i) |=> (mode_o == 2'd2));

  a_r6_two_point_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!four_point_i && cmp_a_tx_i) |=> (mode_o == 2'd1));

  a_r6_two_point_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!four_point_i && !cmp_a_tx_i) |=> (mode_o == 2'd2));

  a_r7_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o == $past(ramp_o)) || (ramp_o == $past(ramp_o) + ONE) ||
    (ramp_o == $past(ramp_o) - ONE));

  a_r8_hold_on_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> (ramp_o == $past(ramp_o)));

  a_r9_tx_end_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o == NEG_END) |-> (tx_att_o == '0 && rx_att_o == '1));
endmodule

bind vsw_ctrl vsw_ctrl_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmp_a_tx_i  (cmp_a_tx_i),
  .cmp_b_tx_i  (cmp_b_tx_i),
  .tx_speech_i (tx_speech_i),
  .rx_speech_i (rx_speech_i),
  .dial_tone_i (dial_tone_i),
  .four_point_i(four_point_i),
  .mode_o      (mode_o),
  .ramp_o      (ramp_o),
  .tx_att_o    (tx_att_o),
  .rx_att_o    (rx_att_o)
);

// File: tb/vsw_ctrl_tb_top.sv
`timescale 1ns/1ps
module vsw_ctrl_tb_top;
  localparam int RAMP_W = 8;
  localparam int FAST   = 2;
  localparam int SLOW   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmp_a = 1'b0, cmp_b = 1'b0, tx_sp = 1'b0, rx_sp = 1'b0, dt = 1'b0, fp = 1'b1;
  logic [1:0] mode;
  logic signed [RAMP_W-1:0] ramp;
  logic [RAMP_W-2:0] tx_att, rx_att;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  vsw_ctrl #(.RAMP_W(RAMP_W), .FAST_DIV(FAST), .SLOW_DIV(SLOW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmp_a_tx_i(cmp_a), .cmp_b_tx_i(cmp_b),
    .tx_speech_i(tx_sp), .rx_speech_i(rx_sp),
    .dial_tone_i(dt), .four_point_i(fp),
    .mode_o(mode), .ramp_o(ramp), .tx_att_o(tx_att), .rx_att_o(rx_att)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input bit a, b, ts, rs, d, f);
    if (!f) return a ? 1 : 2;
    if (a && b) return ts ? 1 : 0;
    if (!a && !b) return (rs || d) ? 2 : 0;
    return (ts || rs) ? 3 : 0;
  endfunction

  function automatic string mode_req(input bit a, b, ts, rs, d, f);
    if (!f) return "R6";
    if (a && b) return ts ? "R1" : "R4";
    if (!a && !b) return rs ? "R2" : (d ? "R5" : "R4");
    return (ts || rs) ? "R3" : "R4";
  endfunction

  function automatic int approach(input int start, input int tgt, input int steps);
    if (start > tgt) return (start - steps < tgt) ? tgt : start - steps;
    return (start + steps > tgt) ? tgt : start + steps;
  endfunction

  // inputs set at a negedge; the first posedge latches the new mode
  task automatic hold(input bit a, b, ts, rs, d, f, input int n, input int em,
                      input int tgt, input int dv, input string req);
    int start;
    int e;
    start = int'(ramp);
    cmp_a = a; cmp_b = b; tx_sp = ts; rx_sp = rs; dt = d; fp = f;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      e = approach(start, tgt, (i - 1) / dv);
      check(mode == 2'(em), {req, " R11 mode"}, int'(mode), em);
      check(int'(ramp) == e, {req, " R7 R8 ramp"}, int'(ramp), e);
      check(int'(tx_att) == (e + 128) / 2, "R9 tx_att", int'(tx_att), (e + 128) / 2);
      check(int'(rx_att) == (127 - e) / 2, "R9 rx_att", int'(rx_att), (127 - e) / 2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(mode == 2'd0, "R10 mode", int'(mode), 0);
    check(ramp == 0, "R10 ramp", int'(ramp), 0);
    check(tx_att == 7'd64, "R10 tx_att", int'(tx_att), 64);
    check(rx_att == 7'd63, "R10 rx_att", int'(rx_att), 63);
    rst_ni = 1'b1;
    @(negedge clk);

    hold(1, 1, 1, 0, 0, 1, 270, 1, -128, FAST, "R1");
    hold(0, 0, 0, 1, 0, 1, 520, 2,  127, FAST, "R2");
    hold(1, 1, 0, 0, 0, 1, 650, 0,    0, SLOW, "R4");
    hold(1, 1, 1, 0, 0, 1,  40, 1, -128, FAST, "R1");
    hold(1, 0, 1, 0, 0, 1,  60, 3,    0, FAST, "R3");
    hold(0, 0, 0, 0, 1, 1,  20, 2,  127, FAST, "R5");
    hold(1, 0, 0, 0, 0, 0,  30, 1, -128, FAST, "R6");
    hold(0, 1, 1, 1, 1, 0,  30, 2,  127, FAST, "R6");

    // exhaustive decision sweep in both sensing modes
    for (int f = 1; f >= 0; f--) begin
      for (int v = 0; v < 32; v++) begin
        cmp_a = v[4]; cmp_b = v[3]; tx_sp = v[2]; rx_sp = v[1]; dt = v[0]; fp = f[0];
        @(posedge clk);
        @(negedge clk);
        check(int'(mode) == exp_mode(v[4], v[3], v[2], v[1], v[0], f[0]),
              mode_req(v[4], v[3], v[2], v[1], v[0], f[0]),
              int'(mode), exp_mode(v[4], v[3], v[2], v[1], v[0], f[0]));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule